// File: doc/BRIEF.md
# SD Bus Speed Mode Switch Sequencer

This block moves an SD card host between bus speed modes. It does not drive the CMD or DAT lines. It asks an external command/data engine to send switch-function commands and reads back each 512-bit status block one byte at a time. From that block it decides the outcome.

To enter a faster mode (high speed, SDR50, SDR104 or DDR50), the block first sends a query command. It checks that the card reports support for the requested function. It then sends a commit command and checks the 4-bit result field that the card returns for function group 1.

Only a successful commit changes the two controls the block owns: a card-clock range selector and a 1.8 V signaling-voltage select. A request to return to default speed skips the query and sends only the commit. Each request ends with a one-cycle completion pulse and a 2-bit result code.

Top module: `sd_speed_switch_seq`

## Requirements
- R1: After reset, `clk_sel` is 0, `vsel_1v8`, `done`, `busy` and `cmd_valid` are all 0.
- R2: A request for mode code m (1 high speed, 2 SDR50, 3 SDR104, 4 DDR50) first issues a query command with argument 0x00FFFFF0 | m. Every command presents a transfer of `xfer_blocks` = 1 block of `xfer_bytes` = 64 bytes.
- R3: The status block arrives most significant byte first, so byte 13 holds bits 407..400. If bit m of that byte (status bit 400+m) is 0 after the query, the block reports result 1 (unsupported), sends no commit, and leaves `clk_sel` and `vsel_1v8` unchanged.
- R4: When the query reports support, the block issues a commit command with argument 0x80FFFFF0 | m.
- R5: After a commit, if the low nibble of status byte 16 (bits 379..376) is 0xF, the block reports result 2 (switch failed) and leaves `clk_sel` and `vsel_1v8` unchanged.
- R6: On a successful commit the block reports result 0 and sets `clk_sel`. The codes are 0 for below 25 MHz, 1 for 50 MHz, 2 for 100 MHz and 3 for 200 MHz. Mode 1 and mode 4 select 1, mode 2 selects 2 and mode 3 selects 3.
- R7: On a successful switch, `vsel_1v8` becomes 1 for modes 2 and 3 and 0 for every other mode.
- R8: A request with mode code 0 returns the card to default speed. It issues only a commit with argument 0x80FFFFF0 and applies the same 0xF check. On success it sets `clk_sel` to 0 and `vsel_1v8` to 0.
- R9: If `cmd_error` is high with `cmd_done` in either phase, the block reports result 3 (transport error), sends no further command, and keeps `clk_sel` and `vsel_1v8` unchanged.
- R10: `done` is high for exactly one cycle per request, with `busy` low in that cycle. A request presented while `busy` is high is ignored.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_arg` stays unchanged.
- R12: A request with mode code 5 to 7 completes in the next cycle with result 1 and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a switch request (taken only when idle) |
| req_mode | input | 3 | Target mode code, 0 = default speed |
| busy | output | 1 | A request is in progress |
| cmd_valid | output | 1 | Switch-function command pending for the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_arg | output | 32 | Command argument |
| xfer_blocks | output | 16 | Block count for the data phase |
| xfer_bytes | output | 12 | Block length in bytes for the data phase |
| cmd_done | input | 1 | Engine finished the command and its data |
| cmd_error | input | 1 | With cmd_done: error or timeout |
| st_valid | input | 1 | Status byte strobe |
| st_byte | input | 8 | Status byte, most significant byte first |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 unsupported, 2 switch failed, 3 transport error |
| clk_sel | output | 2 | Card clock range selector |
| vsel_1v8 | output | 1 | 1.8 V signaling select |

## Verification
The embedded properties watch several rules on every cycle: a pending command holds steady until it is accepted, completion is a single-cycle pulse taken in idle, and the clock and voltage controls move only in a successful completion cycle and stay fixed on any failed one. The bench scenarios are the only way to show the rest. These are the exact argument sequences, the reading of the correct status bytes while the other bytes carry decoy values, the mode-to-clock and mode-to-voltage mapping, and the rejection of a request made mid-transfer.

// File: rtl/sd_speed_switch_seq.sv
module sd_speed_switch_seq #(
  parameter int STATUS_BITS = 512,
  parameter int SUP_BIT_LO  = 400,
  parameter int FAIL_BIT_LO = 376,
  parameter int MAX_MODE    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_mode,
  output logic        busy,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [31:0] cmd_arg,
  output logic [15:0] xfer_blocks,
  output logic [11:0] xfer_bytes,
  input  logic        cmd_done,
  input  logic        cmd_error,
  input  logic        st_valid,
  input  logic [7:0]  st_byte,
  output logic        done,
  output logic [1:0]  result,
  output logic [1:0]  clk_sel,
  output logic        vsel_1v8
);
  localparam int NBYTES   = STATUS_BITS / 8;
  localparam int CW       = $clog2(NBYTES);
  localparam int SUP_IDX  = (STATUS_BITS - 1 - SUP_BIT_LO) / 8;
  localparam int FAIL_IDX = (STATUS_BITS - 1 - FAIL_BIT_LO) / 8;

  typedef enum logic [2:0] {S_IDLE, S_QISS, S_QWAIT, S_CISS, S_CWAIT} st_t;

  st_t         st;
  logic [2:0]  mode_q;
  logic [CW-1:0] bcnt;
  logic [7:0]  sup_q;
  logic [3:0]  fail_q;

  assign busy        = st != S_IDLE;
  assign cmd_valid   = (st == S_QISS) || (st == S_CISS);
  assign cmd_arg     = {st == S_CISS, 7'd0, 20'hFFFFF, 1'b0, mode_q};
  assign xfer_blocks = 16'd1;
  assign xfer_bytes  = 12'(NBYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= '0;
      bcnt     <= '0;
      sup_q    <= '0;
      fail_q   <= '0;
      done     <= 1'b0;
      result   <= '0;
      clk_sel  <= '0;
      vsel_1v8 <= 1'b0;
    end else begin
      done <= 1'b0;
      if ((st == S_QWAIT || st == S_CWAIT) && st_valid) begin
        bcnt <= bcnt + 1'b1;
        if (st == S_QWAIT && bcnt == CW'(SUP_IDX))  sup_q  <= st_byte;
        if (st == S_CWAIT && bcnt == CW'(FAIL_IDX)) fail_q <= st_byte[3:0];
      end
      case (st)
        S_IDLE: if (req_valid) begin
          if (int'(req_mode) > MAX_MODE) begin
            done   <= 1'b1;
            result <= 2'd1;
          end else begin
            mode_q <= req_mode;
            st     <= (req_mode == 3'd0) ? S_CISS : S_QISS;
          end
        end
        S_QISS, S_CISS: if (cmd_ready) begin
          bcnt <= '0;
          st   <= (st == S_QISS) ? S_QWAIT : S_CWAIT;
        end
        S_QWAIT: if (cmd_done) begin
          if (cmd_error) begin
            done <= 1'b1; result <= 2'd3; st <= S_IDLE;
          end else if (!sup_q[mode_q]) begin
            done <= 1'b1; result <= 2'd1; st <= S_IDLE;
          end else begin
            st <= S_CISS;
          end
        end
        S_CWAIT: if (cmd_done) begin
          done <= 1'b1;
          st   <= S_IDLE;
          if (cmd_error)            result <= 2'd3;
          else if (fail_q == 4'hF)  result <= 2'd2;
          else begin
            result   <= 2'd0;
            vsel_1v8 <= (mode_q == 3'd2) || (mode_q == 3'd3);
            case (mode_q)
              3'd1, 3'd4: clk_sel <= 2'd1;
              3'd2:       clk_sel <= 2'd2;
              3'd3:       clk_sel <= 2'd3;
              default:    clk_sel <= 2'd0;
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_arg));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  clk_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel) |-> done && result == 2'd0);
  // R7
  vsel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsel_1v8) |-> done && result == 2'd0 && clk_sel >= 2'd2);
  // R9
  keep_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && result != 2'd0 |-> $stable(clk_sel) && $stable(vsel_1v8));
endmodule

// File: tb/sd_speed_switch_seq_tb.sv
module sd_speed_switch_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_mode = '0;
  logic busy, cmd_valid, done, vsel_1v8;
  logic cmd_ready = 1'b0, cmd_done = 1'b0, cmd_error = 1'b0, st_valid = 1'b0;
  logic [7:0] st_byte = '0;
  logic [31:0] cmd_arg;
  logic [15:0] xfer_blocks;
  logic [11:0] xfer_bytes;
  logic [1:0] result, clk_sel;

  int checks = 0, errors = 0;
  logic [1:0] exp_clk = 2'd0;
  logic exp_vsel = 1'b0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_speed_switch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_arg(cmd_arg),
    .xfer_blocks(xfer_blocks), .xfer_bytes(xfer_bytes), .cmd_done(cmd_done),
    .cmd_error(cmd_error), .st_valid(st_valid), .st_byte(st_byte), .done(done),
    .result(result), .clk_sel(clk_sel), .vsel_1v8(vsel_1v8));

  // {mode, support byte, commit nibble, error phase, expected result, expected commands}
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {3'd1, 8'h02, 4'h0, 2'd0, 2'd0, 2'd2},
    {3'd3, 8'h08, 4'h1, 2'd0, 2'd0, 2'd2},
    {3'd2, 8'hFB, 4'h0, 2'd0, 2'd1, 2'd1},
    {3'd4, 8'h10, 4'hF, 2'd0, 2'd2, 2'd2},
    {3'd2, 8'h04, 4'h0, 2'd1, 2'd3, 2'd1},
    {3'd2, 8'h04, 4'h0, 2'd2, 2'd3, 2'd2},
    {3'd0, 8'h00, 4'h0, 2'd0, 2'd0, 2'd1},
    {3'd2, 8'h04, 4'hE, 2'd0, 2'd0, 2'd2},
    {3'd4, 8'h10, 4'h0, 2'd0, 2'd0, 2'd2},
    {3'd6, 8'hFF, 4'h0, 2'd0, 2'd1, 2'd0},
    {3'd0, 8'h00, 4'hF, 2'd0, 2'd2, 2'd1},
    {3'd0, 8'h00, 4'h0, 2'd1, 2'd3, 2'd1},
    {3'd3, 8'hF7, 4'h0, 2'd0, 2'd1, 2'd1},
    {3'd5, 8'hFF, 4'h0, 2'd0, 2'd1, 2'd0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic run_req(input logic [2:0] m, input logic [7:0] sup, input logic [3:0] nib,
                         input logic [1:0] errph, input logic [1:0] eres, input logic [1:0] encmd,
                         input bit poke);
    int ncmd = 0;
    int guard = 0;
    string rtag;
    @(negedge clk); req_valid = 1'b1; req_mode = m;
    @(negedge clk); req_valid = 1'b0;
    check(busy == (m <= 3'd4), "R10", 32'(busy), 32'(m <= 3'd4));
    while (!done && guard < 2000) begin
      if (cmd_valid) begin
        logic [31:0] ea, held;
        bit query;
        query = (m != 3'd0) && (ncmd == 0);
        ea = query ? (32'h00FFFFF0 | 32'(m)) : (32'h80FFFFF0 | 32'(m));
        check(cmd_arg == ea, query ? "R2" : (m == 3'd0 ? "R8" : "R4"), cmd_arg, ea);
        check(xfer_blocks == 16'd1 && xfer_bytes == 12'd64, "R2",
              {xfer_blocks, 4'd0, xfer_bytes}, {16'd1, 16'd64});
        held = cmd_arg;
        @(negedge clk);
        check(cmd_valid && cmd_arg == held, "R11", cmd_arg, held);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        for (int i = 0; i < 64; i++) begin
          st_valid = 1'b1;
          if (i == 13)      st_byte = query ? sup : 8'h00;
          else if (i == 16) st_byte = {4'hA, nib};
          else              st_byte = query ? ~sup : {4'hF, ~nib};
          req_valid = poke && (i == 5);
          req_mode  = 3'd3;
          @(negedge clk);
        end
        st_valid = 1'b0; req_valid = 1'b0;
        cmd_done = 1'b1;
        cmd_error = (32'(errph) == ncmd + 1);
        ncmd++;
        @(negedge clk);
        cmd_done = 1'b0; cmd_error = 1'b0;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    check(done, "R10", 32'(done), 32'd1);
    case (eres)
      2'd0: rtag = (m == 3'd0) ? "R8" : "R6";
      2'd1: rtag = (m > 3'd4) ? "R12" : "R3";
      2'd2: rtag = "R5";
      default: rtag = "R9";
    endcase
    check(result == eres, rtag, 32'(result), 32'(eres));
    check(ncmd == int'(encmd), rtag, ncmd, 32'(encmd));
    if (eres == 2'd0) begin
      case (m)
        3'd1, 3'd4: exp_clk = 2'd1;
        3'd2: exp_clk = 2'd2;
        3'd3: exp_clk = 2'd3;
        default: exp_clk = 2'd0;
      endcase
      exp_vsel = (m == 3'd2) || (m == 3'd3);
    end
    check(clk_sel == exp_clk, (eres == 2'd0) ? "R6" : rtag, 32'(clk_sel), 32'(exp_clk));
    check(vsel_1v8 == exp_vsel, (eres == 2'd0) ? "R7" : rtag, 32'(vsel_1v8), 32'(exp_vsel));
    @(negedge clk);
    check(!done, "R10", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(clk_sel == 2'd0 && !vsel_1v8, "R1", {clk_sel, vsel_1v8}, 32'd0);
    check(!done && !busy && !cmd_valid, "R1", {done, busy, cmd_valid}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [20:0] e;
      e = VEC[v];
      run_req(e[20:18], e[17:10], e[9:6], e[5:4], e[3:2], e[1:0], 1'b0);
    end

    // R10: request while busy is ignored
    run_req(3'd1, 8'h02, 4'h0, 2'd0, 2'd0, 2'd2, 1'b1);
    for (int i = 0; i < 6; i++) begin
      check(!cmd_valid && !done && !busy, "R10", {cmd_valid, done, busy}, 32'd0);
      @(negedge clk);
    end
    check(clk_sel == 2'd1, "R10", 32'(clk_sel), 32'd1);
    finish_up();
  end
endmodule